// File: doc/BRIEF.md
# Per-Line Edge Interrupt Capture Unit

This unit watches a group of already-synchronized I/O pin levels and raises an interrupt when a line sees an edge in the direction chosen for it. Each line has its own enable bit and edge-sense bit. A rising sense (1) detects a low-to-high change and a falling sense (0) detects a high-to-low change. Detection always works on the true pin level. A qualifying edge on an enabled line sets that line's bit in a sticky identification vector. The bit stays set until software clears it through a byte-wide write port.

The lines are grouped into byte-sized ports. The unit gives a one-bit-per-port pending summary, laid out as a byte, and an interrupt request that is the OR of all captured bits. Software reads the summary to find which port needs service, reads that port's identification byte, and then writes zeros to the bits it has handled. With the default parameters there are 24 lines in three ports.

Top module: `eiu_edge_irq`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `id_vec`, `pend_byte` and `irq` are all zero. A pin level that is already present when reset ends is not treated as an edge.
- R2: Line k sets `id_vec[k]` on the clock edge where `pin_lvl[k]` is first sampled at its new level. With `pol_sel[k]`=1 this happens when the sample goes 0 then 1. With `pol_sel[k]`=0 it happens when the sample goes 1 then 0. The bit is visible from that edge onward. An edge in the other direction leaves the bit unchanged.
- R3: A line with `line_en[k]`=0 never sets its bit. With every enable cleared, no edge is captured.
- R4: A captured bit stays set until it is cleared, even after the pin returns to its old level. A clear happens when `id_wr_en[p]` is 1 for a clock. Bit i of `id_wr_data` then controls line 8p+i: a 0 clears that line's bit and a 1 leaves it as it is. Ports whose strobe is 0 are not affected.
- R5: If a qualifying edge and a clear of the same bit happen on the same clock, the edge wins and the bit stays set.
- R6: `pend_byte[p]` is the OR of lines 8p to 8p+7 of `id_vec` for each port p. `pend_byte` bits 7:3 are always 0.
- R7: `irq` is a level that is high exactly while any bit of `id_vec` is set.
- R8: Edges are detected against the pin sample from the previous clock. Changing `pol_sel` or `line_en` while a pin is steady does not set any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 24 | Synchronized true pin levels |
| pol_sel | input | 24 | Edge sense per line: 1 rising, 0 falling |
| line_en | input | 24 | Capture enable per line |
| id_wr_en | input | 3 | Per-port write strobe for the identification bytes |
| id_wr_data | input | 8 | Write byte: 0 clears a bit, 1 keeps it |
| id_vec | output | 24 | Sticky captured-edge bits |
| pend_byte | output | 8 | Per-port pending summary in bits 2:0, zeros above |
| irq | output | 1 | Interrupt request level |

## Verification
A pin change driven between clock edges appears in `id_vec` one clock later. `pend_byte` and `irq` follow `id_vec` combinationally in that same cycle. A clear write takes effect on the edge that samples the strobe, so the cleared value is read one cycle after the write is driven. The bench drives every stimulus on a falling clock edge and samples on the next falling edge, exactly one register stage later. It also checks that a stimulus which must have no effect leaves all three outputs unchanged at that same point.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

   // Meaning of one edge-sense bit.
   typedef enum logic {
      EDGE_FALLING = 1'b0,
      EDGE_RISING  = 1'b1
   } edge_sense_e;

   // Number of byte-sized ports needed to hold a given number of lines.
   function automatic int unsigned ports_for(input int unsigned lines,
                                             input int unsigned width);
      return (lines + width - 1) / width;
   endfunction

endpackage

// File: rtl/eiu_edge_det.sv
// Edge qualifier for one port: compares each line with its previous sample.
module eiu_edge_det #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] en,
   output logic [W-1:0] hit
);
   import eiu_pkg::*;

   logic [W-1:0] prev_q;
   logic         primed_q;
   logic [W-1:0] rise;
   logic [W-1:0] fall;

   // The previous sample tracks the pin even in reset, so the level held
   // when reset ends becomes the reference rather than a fake edge.
   always_ff @(posedge clk) begin
      prev_q <= lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   generate
      for (genvar i = 0; i < W; i++) begin : g_line
         assign hit[i] = primed_q & en[i] &
                         ((edge_sense_e'(pol[i]) == EDGE_RISING) ? rise[i] : fall[i]);
      end
   endgenerate

endmodule

// File: rtl/eiu_id_bank.sv
// Sticky capture byte for one port; write-zero clears, edge beats clear.
module eiu_id_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] id
);
   logic [W-1:0] id_q;
   logic [W-1:0] keep;

   always_comb begin
      keep = wr_en ? wr_data : {W{1'b1}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) id_q <= '0;
      else        id_q <= (id_q & keep) | hit;
   end

   assign id = id_q;

endmodule

// File: rtl/eiu_pend_sum.sv
// Per-port pending summary and interrupt request.
module eiu_pend_sum #(
   parameter int unsigned NP = 3,
   parameter int unsigned PW = 8
) (
   input  logic [NP*PW-1:0] id,
   output logic [PW-1:0]    pend,
   output logic             irq
);
   logic [NP-1:0] port_any;

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         assign port_any[p] = |id[p*PW +: PW];
      end
      if (PW > NP) begin : g_pad
         assign pend = {{(PW-NP){1'b0}}, port_any};
      end else begin : g_full
         assign pend = port_any;
      end
   endgenerate

   assign irq = |port_any;

endmodule

// File: rtl/eiu_edge_irq.sv
// Top: per-port edge qualifier and capture bank, then the summary.
module eiu_edge_irq #(
   parameter int unsigned NUM_LINES = 24,
   parameter int unsigned PORT_W    = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_LINES-1:0]            pin_lvl,
   input  logic [NUM_LINES-1:0]            pol_sel,
   input  logic [NUM_LINES-1:0]            line_en,
   input  logic [eiu_pkg::ports_for(NUM_LINES, PORT_W)-1:0] id_wr_en,
   input  logic [PORT_W-1:0]               id_wr_data,
   output logic [NUM_LINES-1:0]            id_vec,
   output logic [PORT_W-1:0]               pend_byte,
   output logic                            irq
);
   localparam int unsigned NUM_PORTS = eiu_pkg::ports_for(NUM_LINES, PORT_W);

   generate
      if (NUM_LINES == 0) begin : g_bad_lines
         $error("eiu_edge_irq: NUM_LINES must be nonzero");
      end
      if (NUM_LINES % PORT_W != 0) begin : g_bad_group
         $error("eiu_edge_irq: NUM_LINES must be a multiple of PORT_W");
      end
      if (NUM_PORTS > PORT_W) begin : g_bad_sum
         $error("eiu_edge_irq: summary byte too narrow for port count");
      end
   endgenerate

   logic [NUM_LINES-1:0] hit_all;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         eiu_edge_det #(.W(PORT_W)) det_i (
            .clk (clk),
            .rst_n (rst_n),
            .lvl (pin_lvl[p*PORT_W +: PORT_W]),
            .pol (pol_sel[p*PORT_W +: PORT_W]),
            .en  (line_en[p*PORT_W +: PORT_W]),
            .hit (hit_all[p*PORT_W +: PORT_W])
         );

         eiu_id_bank #(.W(PORT_W)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit_all[p*PORT_W +: PORT_W]),
            .wr_en   (id_wr_en[p]),
            .wr_data (id_wr_data),
            .id      (id_vec[p*PORT_W +: PORT_W])
         );
      end
   endgenerate

   eiu_pend_sum #(.NP(NUM_PORTS), .PW(PORT_W)) sum_i (
      .id   (id_vec),
      .pend (pend_byte),
      .irq  (irq)
   );

endmodule

// File: rtl/eiu_edge_irq_chk.sv
// Property checker bound onto the top module.
module eiu_edge_irq_chk #(
   parameter int unsigned NUM_LINES = 24,
   parameter int unsigned PORT_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] pin_lvl,
   input logic [NUM_LINES-1:0] pol_sel,
   input logic [NUM_LINES-1:0] line_en,
   input logic [eiu_pkg::ports_for(NUM_LINES, PORT_W)-1:0] id_wr_en,
   input logic [PORT_W-1:0]    id_wr_data,
   input logic [NUM_LINES-1:0] id_vec,
   input logic [PORT_W-1:0]    pend_byte,
   input logic                 irq
);
   localparam int unsigned NP = eiu_pkg::ports_for(NUM_LINES, PORT_W);

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= 2'd0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   // R2: a newly set bit matches the selected edge direction.
   a_r2_edge_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (id_vec & ~$past(id_vec) & ($past(pin_lvl) ^ $past(pol_sel))) == '0);

   // R3: a newly set bit needs its enable.
   a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (id_vec & ~$past(id_vec) & ~$past(line_en)) == '0);

   // R5: a qualifying edge always leaves its bit set, clear or not.
   a_r5_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |->
      ((( $past(line_en) &  $past(pin_lvl) & ~$past(pin_lvl, 2) &  $past(pol_sel)) |
        ( $past(line_en) & ~$past(pin_lvl) &  $past(pin_lvl, 2) & ~$past(pol_sel)))
       & ~id_vec) == '0);

   // R7: interrupt level follows the captured bits.
   a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (id_vec != '0));

   // R6: summary bits above the port count stay zero.
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_byte >> NP) == '0);

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         // R4: a bit only falls after a strobe on its port.
         a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            (|(~id_vec[p*PORT_W +: PORT_W] & $past(id_vec[p*PORT_W +: PORT_W])))
            |-> $past(id_wr_en[p]));
         // R4: only bits written as zero may fall.
         a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (~id_vec[p*PORT_W +: PORT_W] & $past(id_vec[p*PORT_W +: PORT_W])
             & $past(id_wr_data)) == '0);
         // R6: summary bit matches its port.
         a_r6_port_summary: assert property (@(posedge clk) disable iff (!rst_n)
            pend_byte[p] == (id_vec[p*PORT_W +: PORT_W] != '0));
      end
   endgenerate

endmodule

bind eiu_edge_irq eiu_edge_irq_chk #(.NUM_LINES(NUM_LINES), .PORT_W(PORT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .pin_lvl    (pin_lvl),
   .pol_sel    (pol_sel),
   .line_en    (line_en),
   .id_wr_en   (id_wr_en),
   .id_wr_data (id_wr_data),
   .id_vec     (id_vec),
   .pend_byte  (pend_byte),
   .irq        (irq)
);

// File: tb/eiu_edge_irq_tb_top.sv
module eiu_edge_irq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 24;
   localparam int PW = 8;
   localparam int NP = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NL-1:0] pin_lvl;
   logic [NL-1:0] pol_sel;
   logic [NL-1:0] line_en;
   logic [NP-1:0] id_wr_en;
   logic [PW-1:0] id_wr_data;
   logic [NL-1:0] id_vec;
   logic [PW-1:0] pend_byte;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eiu_edge_irq #(.NUM_LINES(NL), .PORT_W(PW)) dut_i (
      .clk (clk), .rst_n (rst_n), .pin_lvl (pin_lvl), .pol_sel (pol_sel),
      .line_en (line_en), .id_wr_en (id_wr_en), .id_wr_data (id_wr_data),
      .id_vec (id_vec), .pend_byte (pend_byte), .irq (irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic expect_out(input string req, input logic [NL-1:0] id,
                             input logic [PW-1:0] pend, input logic rq);
      chk(req, "id_vec", 32'(id_vec), 32'(id));
      chk(req, "pend_byte", 32'(pend_byte), 32'(pend));
      chk(req, "irq", 32'(irq), 32'(rq));
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_id(input logic [NP-1:0] ports, input logic [PW-1:0] data);
      id_wr_en   = ports;
      id_wr_data = data;
      step();
      id_wr_en   = '0;
      id_wr_data = '0;
   endtask

   // R1: reset values and no edge from the level held through reset.
   task automatic t_reset();
      rst_n = 1'b0;
      pin_lvl = '1; pol_sel = '1; line_en = '1;
      id_wr_en = '0; id_wr_data = '0;
      repeat (3) step();
      expect_out("R1", '0, 8'h00, 1'b0);
      rst_n = 1'b1;
      step();
      expect_out("R1", '0, 8'h00, 1'b0);
      step();
      expect_out("R1", '0, 8'h00, 1'b0);
   endtask

   // R3: falling edges on every line with enables off capture nothing.
   task automatic t_all_disabled();
      line_en = '0; pol_sel = '0;
      pin_lvl = '0;
      step();
      expect_out("R3", '0, 8'h00, 1'b0);
   endtask

   // R2 rising sense, R4 sticky, R7 irq, R4 clear.
   task automatic t_rise();
      pol_sel[3] = 1'b1; line_en[3] = 1'b1;
      step();
      pin_lvl[3] = 1'b1;
      step();
      expect_out("R2", 24'h000008, 8'h01, 1'b1);
      pin_lvl[3] = 1'b0;
      step();
      expect_out("R4", 24'h000008, 8'h01, 1'b1);
      write_id(3'b001, 8'h00);
      expect_out("R4", '0, 8'h00, 1'b0);
   endtask

   // R2 falling sense, R4 partial clear, R6 summary, R7 level.
   task automatic t_fall_and_partial();
      pol_sel[17] = 1'b0; line_en[17] = 1'b1;
      pol_sel[20] = 1'b0; line_en[20] = 1'b1;
      pol_sel[9]  = 1'b1; line_en[9]  = 1'b1;
      step();
      pin_lvl[17] = 1'b1; pin_lvl[20] = 1'b1;
      step();
      expect_out("R2", '0, 8'h00, 1'b0);
      pin_lvl[17] = 1'b0; pin_lvl[20] = 1'b0;
      step();
      expect_out("R2", 24'h120000, 8'h04, 1'b1);
      pin_lvl[9] = 1'b1;
      step();
      expect_out("R6", 24'h120200, 8'h06, 1'b1);
      write_id(3'b100, 8'hFD);
      expect_out("R4", 24'h100200, 8'h06, 1'b1);
      write_id(3'b010, 8'h00);
      expect_out("R7", 24'h100000, 8'h04, 1'b1);
      write_id(3'b100, 8'h00);
      expect_out("R7", '0, 8'h00, 1'b0);
      pin_lvl[9] = 1'b0;
      line_en = '0;
      step();
   endtask

   // R5: an edge on the same clock as a clear keeps its bit.
   task automatic t_edge_wins();
      pol_sel[5] = 1'b1; line_en[5] = 1'b1;
      pol_sel[6] = 1'b1; line_en[6] = 1'b1;
      step();
      pin_lvl[5] = 1'b1; pin_lvl[6] = 1'b1;
      step();
      expect_out("R5", 24'h000060, 8'h01, 1'b1);
      pin_lvl[5] = 1'b0;
      step();
      pin_lvl[5] = 1'b1;
      write_id(3'b001, 8'h00);
      expect_out("R5", 24'h000020, 8'h01, 1'b1);
      write_id(3'b001, 8'h00);
      expect_out("R5", '0, 8'h00, 1'b0);
      line_en = '0;
      pin_lvl = '0;
      step();
   endtask

   // R8: configuration changes on a steady pin create no edge.
   task automatic t_cfg_change();
      pin_lvl[12] = 1'b1; pol_sel[12] = 1'b1; line_en[12] = 1'b0;
      step();
      line_en[12] = 1'b1;
      step();
      expect_out("R8", '0, 8'h00, 1'b0);
      pol_sel[12] = 1'b0;
      step();
      expect_out("R8", '0, 8'h00, 1'b0);
      pol_sel[12] = 1'b1;
      step();
      expect_out("R8", '0, 8'h00, 1'b0);
      pin_lvl[12] = 1'b0;
      step();
      expect_out("R2", '0, 8'h00, 1'b0);
   endtask

   // R3 all enables cleared, R8 enable-on with steady pins, R6 full summary.
   task automatic t_global();
      line_en = '1; pol_sel = '1; pin_lvl = '0;
      step();
      line_en = '0;
      pin_lvl = '1;
      step();
      expect_out("R3", '0, 8'h00, 1'b0);
      line_en = '1;
      step();
      expect_out("R8", '0, 8'h00, 1'b0);
      pin_lvl = '0;
      step();
      expect_out("R2", '0, 8'h00, 1'b0);
      pin_lvl = '1;
      step();
      expect_out("R6", 24'hFFFFFF, 8'h07, 1'b1);
      write_id(3'b111, 8'hFF);
      expect_out("R4", 24'hFFFFFF, 8'h07, 1'b1);
      write_id(3'b111, 8'h00);
      expect_out("R4", '0, 8'h00, 1'b0);
   endtask

   initial begin
      t_reset();
      t_all_disabled();
      t_rise();
      t_fall_and_partial();
      t_edge_wins();
      t_cfg_change();
      t_global();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule